// File: doc/BRIEF.md
# Lane-Preserving Thread Block Compactor

After a divergent branch, every static warp of a thread block holds an active mask for the path taken. This block takes all of those masks at once, as one block-wide vector for one path. It then regroups the active threads into the fewest dynamic warps it can. A thread never leaves its home SIMD lane, which is its thread index modulo the warp width. As a result, register file banking stays intact, and a block with no divergence comes back in exactly its static warp arrangement.

A mask vector is taken in through a valid/ready handshake. The block then emits one compacted warp per accepted output cycle. Each compacted warp gives, for every lane, a valid flag and the thread ID that the lane runs. A single-cycle done pulse follows the last warp. Within a lane, threads are handed out in ascending static warp order, so the output is fully deterministic. The number of warps emitted equals the largest number of active threads found in any one lane.

Top module: `tbc_lane_compactor`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, in_ready_o is 1, out_valid_o is 0 and done_o is 0.
- R2: Mask bit w*LANES+l stands for thread ID w*LANES+l (0-based), which lives in static warp w and lane l. A thread reported on lane l always has an ID congruent to l modulo LANES.
- R3: Within each lane, active threads appear in ascending static warp index, one per emitted warp. A lane shows valid=0 once its threads are used up.
- R4: The number of warps emitted for a mask equals the largest per-lane count of active threads. No warp with all lanes invalid is ever emitted.
- R5: An all-ones mask yields the static warps unchanged, warp 0 first, each with every lane valid.
- R6: While out_valid_o is 1 and out_ready_i is 0, the warp on the outputs holds unchanged. Each cycle with both high advances to the next warp.
- R7: done_o is high for exactly one cycle, the cycle after the handshake of the last warp, and never together with out_valid_o.
- R8: An all-zero mask produces no warp. done_o pulses in the cycle after that mask is accepted.
- R9: The block accepts a mask only when in_ready_o is 1. in_ready_o falls after an acceptance and rises again only in the cycle after done_o. Any in_valid_i or in_mask_i activity in between has no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Block-wide mask offered |
| in_ready_o | output | 1 | Compactor idle, mask can be taken |
| in_mask_i | input | WARPS*LANES | Active bits, bit w*LANES+l = thread w*LANES+l |
| out_valid_o | output | 1 | Compacted warp present |
| out_ready_i | input | 1 | Consumer takes the compacted warp |
| out_lane_vld_o | output | LANES | Per-lane thread present |
| out_tid_o | output | LANES*$clog2(WARPS*LANES) | Per-lane thread ID, lane l at bits l*TID_W upward |
| done_o | output | 1 | One-cycle pulse after the last warp |

## Verification
The two paths of a divergent if/else are applied to a twelve-thread block. One path spreads its threads evenly over the lanes. The other places several threads from different warps in one lane, which exposes errors in lane priority and in warp count. A full mask separates true compaction from mere repacking, because the static order must come back. A single-lane column and a single thread push the warp count to its maximum and its minimum. An empty mask checks the path with no warps. Pseudo-random backpressure and a stray in_valid_i asserted while busy show whether the output holds steady under stall and whether a busy compactor ignores new input.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } tbc_state_e;
endpackage

// File: rtl/tbc_lane_pick.sv
// Lowest-warp-first pick within one lane column.
module tbc_lane_pick #(
  parameter int WARPS  = 3,
  parameter int WIDX_W = (WARPS > 1) ? $clog2(WARPS) : 1
) (
  input  logic [WARPS-1:0]  col_i,
  output logic [WARPS-1:0]  grant_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              any_o
);
  always_comb begin
    grant_o = '0;
    widx_o  = '0;
    any_o   = 1'b0;
    for (int w = 0; w < WARPS; w++) begin
      if (col_i[w] && !any_o) begin
        grant_o[w] = 1'b1;
        widx_o     = WIDX_W'(w);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbc_seq_ctrl.sv
module tbc_seq_ctrl
  import tbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic out_ready_i,
  input  logic load_any_i,
  input  logic left_any_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic done_o,
  output logic load_o,
  output logic fire_o
);
  tbc_state_e st_q, st_d;

  assign in_ready_o  = (st_q == ST_IDLE);
  assign out_valid_o = (st_q == ST_EMIT);
  assign done_o      = (st_q == ST_DONE);
  assign load_o      = in_ready_o & in_valid_i;
  assign fire_o      = out_valid_o & out_ready_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (load_o) st_d = load_any_i ? ST_EMIT : ST_DONE;
      ST_EMIT: if (fire_o && !left_any_i) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/tbc_lane_compactor.sv
module tbc_lane_compactor #(
  parameter int LANES = 4,
  parameter int WARPS = 3,
  localparam int NTHR   = LANES * WARPS,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WIDX_W = (WARPS > 1) ? $clog2(WARPS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [NTHR-1:0]        in_mask_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [LANES-1:0]       out_lane_vld_o,
  output logic [LANES*TID_W-1:0] out_tid_o,
  output logic                   done_o
);
  logic [NTHR-1:0] mask_q, clr_mask, left_mask;
  logic            load, fire;

  logic [LANES-1:0][WARPS-1:0]  col, grant;
  logic [LANES-1:0][WIDX_W-1:0] widx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar w = 0; w < WARPS; w++) begin : g_warp
      assign col[l][w]             = mask_q[w*LANES+l];
      assign clr_mask[w*LANES+l]   = grant[l][w];
    end

    tbc_lane_pick #(.WARPS(WARPS), .WIDX_W(WIDX_W)) u_pick (
      .col_i   (col[l]),
      .grant_o (grant[l]),
      .widx_o  (widx[l]),
      .any_o   (out_lane_vld_o[l])
    );

    assign out_tid_o[l*TID_W +: TID_W] = TID_W'(int'(widx[l]) * LANES + l);
  end

  assign left_mask = mask_q & ~clr_mask;

  tbc_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .load_any_i  (|in_mask_i),
    .left_any_i  (|left_mask),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .done_o      (done_o),
    .load_o      (load),
    .fire_o      (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (load) mask_q <= in_mask_i;
    else if (fire) mask_q <= left_mask;
  end
endmodule

// File: rtl/tbc_lane_compactor_chk.sv
module tbc_lane_compactor_chk #(
  parameter int LANES = 4,
  parameter int WARPS = 3,
  localparam int NTHR  = LANES * WARPS,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic [NTHR-1:0]        in_mask_i,
  input logic                   out_valid_o,
  input logic                   out_ready_i,
  input logic [LANES-1:0]       out_lane_vld_o,
  input logic [LANES*TID_W-1:0] out_tid_o,
  input logic                   done_o
);
  a_r4_no_empty_warp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (|out_lane_vld_o));

  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_lane_vld_o) && $stable(out_tid_o)));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o);

  a_r9_busy_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  a_r9_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> $past(done_o));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    a_r2_home_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_lane_vld_o[l]) |->
        ((int'(out_tid_o[l*TID_W +: TID_W]) % LANES) == l));
  end
endmodule

bind tbc_lane_compactor tbc_lane_compactor_chk #(.LANES(LANES), .WARPS(WARPS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .in_ready_o     (in_ready_o),
  .in_mask_i      (in_mask_i),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_lane_vld_o (out_lane_vld_o),
  .out_tid_o      (out_tid_o),
  .done_o         (done_o)
);

// File: tb/tbc_lane_compactor_bench.sv
module tbc_lane_compactor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int WARPS = 3;
  localparam int NTHR  = LANES * WARPS;
  localparam int TID_W = $clog2(NTHR);

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic [NTHR-1:0]        in_mask = '0;
  logic                   out_valid;
  logic                   out_ready = 1'b0;
  logic [LANES-1:0]       lane_vld;
  logic [LANES*TID_W-1:0] tid;
  logic                   done;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model: 0 idle, 1 emitting, 2 done
  int m_state = 0;
  int lq [LANES][$];
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbc_lane_compactor #(.LANES(LANES), .WARPS(WARPS)) u_tbc_lane_compactor (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .in_valid_i     (in_valid),
    .in_ready_o     (in_ready),
    .in_mask_i      (in_mask),
    .out_valid_o    (out_valid),
    .out_ready_i    (out_ready),
    .out_lane_vld_o (lane_vld),
    .out_tid_o      (tid),
    .done_o         (done)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "in_ready (R9)", int'(in_ready), int'(m_state == 0));
    check(tag, "out_valid (R4)", int'(out_valid), int'(m_state == 1));
    check(tag, "done (R7)", int'(done), int'(m_state == 2));
    if (m_state == 1) begin
      for (int l = 0; l < LANES; l++) begin
        check(tag, $sformatf("lane%0d valid (R3)", l), int'(lane_vld[l]), int'(lq[l].size() > 0));
        if (lq[l].size() > 0)
          check(tag, $sformatf("lane%0d tid (R2)", l), int'(tid[l*TID_W +: TID_W]), lq[l][0]);
      end
    end
  endtask

  // one mask through the block; mode bit0: backpressure, bit1: stray in_valid while busy
  task automatic run_block(input string tag, input logic [NTHR-1:0] m, input int mode);
    bit taken = 0;
    while (!(taken && m_state == 0)) begin
      @(negedge clk);
      compare(tag);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = mode[0] ? lfsr[0] : 1'b1;
      if (m_state == 0 && !taken) begin
        in_valid = 1'b1;
        in_mask  = m;
      end else if (m_state == 1 && mode[1]) begin
        in_valid = 1'b1;
        in_mask  = ~m;
      end else begin
        in_valid = 1'b0;
        in_mask  = '0;
      end
      // advance model to match the coming edge
      if (m_state == 0 && in_valid) begin
        taken = 1;
        for (int l = 0; l < LANES; l++)
          for (int w = 0; w < WARPS; w++)
            if (m[w*LANES+l]) lq[l].push_back(w*LANES + l);
        m_state = (m != '0) ? 1 : 2;
      end else if (m_state == 1 && out_ready) begin
        int left = 0;
        for (int l = 0; l < LANES; l++) begin
          if (lq[l].size() > 0) void'(lq[l].pop_front());
          left += lq[l].size();
        end
        if (left == 0) m_state = 2;
      end else if (m_state == 2) begin
        m_state = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", int'(in_ready), 1);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "done in reset", int'(done), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
    run_block("R2", 12'hCD3, 0);  // if-path of the 12-thread example
    run_block("R3", 12'h32C, 0);  // else-path, lane1 shared by warps 1 and 2
    run_block("R5", 12'hFFF, 0);  // no divergence
    run_block("R4", 12'h111, 0);  // lane0 only: three warps
    run_block("R6", 12'hCD3, 1);  // backpressure
    run_block("R8", 12'h000, 0);  // empty
    run_block("R9", 12'h32C, 2);  // stray in_valid while busy
    run_block("R7", 12'h800, 3);  // single thread, stall and stray input
    run_block("R6", 12'hFFF, 1);
    repeat (2) @(negedge clk);
    compare("R9");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule